// File: doc/BRIEF.md
# Chained Vector Pipeline Sequencer

This block steps vector arithmetic instructions through one deeply pipelined functional unit, launching one element per cycle. An instruction names a destination register, two source registers, an operation and an element count. The block reads both source elements through an external register-file read port, computes the result, carries it through a fixed number of pipeline stages, and writes it back through an external write port. Elements of one vector do not depend on each other, so once an instruction starts it launches a new element every cycle.

Two timing rules govern how instructions follow one another. The first is a fixed dead time: a set number of idle launch slots always separates the last element of one instruction from the first element of the next. The second is chaining: an instruction that reads a register still being written by an earlier instruction may begin as soon as the earlier one has written the element it needs. It does not have to wait for the whole vector. A chaining enable input turns this off. When it is off, a dependent instruction waits until the producer has written its final element, which makes the two policies easy to compare. The block tracks, for each register, whether a write to it is still pending and how many elements have been written so far.

Top module: `chain_vec_seq`

## Requirements
- R1: After reset, `issueReady` is 1 and `busy`, `done` and `wrEn` are 0.
- R2: Each written element `i` of the destination equals op(srcA[i], srcB[i]). The `issueOp` encoding is 0 = add, 1 = subtract (A minus B), 2 = multiply (low 32 bits) and 3 = bitwise XOR. Only elements 0 to length-1 of the destination change.
- R3: An instruction's elements appear on the write port on consecutive cycles, with ascending index starting at 0. When nothing delays it, element 0 is written PIPE_DEPTH+1 cycles after the issue handshake cycle.
- R4: For two independent instructions issued back to back, the first write of the second comes DEAD_CYCLES+1 cycles after the last write of the first.
- R5: With `chainEn` = 1, a consumer reads source element `i` only after the producer has written that element. For a producer of length L followed at once by its consumer, the consumer's first write comes max(DEAD_CYCLES+1, PIPE_DEPTH+2-L) cycles after the producer's last write.
- R6: With `chainEn` = 0, a consumer of a register that is still being written waits for the producer's final write. Its first write comes PIPE_DEPTH+1 cycles after the producer's last write.
- R7: `issueReady` stays low while the requested destination still has unwritten elements from an earlier instruction. Such a second writer to the same register produces its first write PIPE_DEPTH+2 cycles after the earlier instruction's last write, and its own results are the ones left in the register.
- R8: A length greater than MAX_LEN (64) is processed as exactly MAX_LEN elements.
- R9: An instruction of length 0 is accepted and ignored: no write, no `busy`, and no register changes.
- R10: `busy` is high from the cycle after an accepted instruction's handshake until the cycle of its last write, and low in the cycle after that when nothing else is pending.
- R11: `done` pulses for one cycle, together with the write of each instruction's last element, once per instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chainEn | input | 1 | 1 lets consumers start on the first produced element |
| issueValid | input | 1 | Instruction offered |
| issueReady | output | 1 | Instruction accepted this cycle when valid |
| issueOp | input | 2 | Operation code |
| issueDst | input | 3 | Destination register |
| issueSrcA | input | 3 | First source register |
| issueSrcB | input | 3 | Second source register |
| issueLen | input | 7 | Element count |
| rdRegA | output | 3 | Register for read port A |
| rdRegB | output | 3 | Register for read port B |
| rdIdx | output | 6 | Element index for both read ports |
| rdDataA | input | 32 | Read data A, same cycle |
| rdDataB | input | 32 | Read data B, same cycle |
| wrEn | output | 1 | Write strobe |
| wrReg | output | 3 | Write register |
| wrIdx | output | 6 | Write element index |
| wrData | output | 32 | Write data |
| busy | output | 1 | Accepted elements not yet written |
| done | output | 1 | Last element of an instruction is being written |

## Verification
The bench targets the cycle distances between instructions. A consumer chained onto a short producer must stall for exactly the missing element. A sequencer that read too early would pull stale source data into the destination, and one that ignored chaining would arrive one or two cycles late. With chaining off, the consumer must wait for the full vector, so a design that still chained would finish early. The bench also covers a second writer to a busy register, where a design that reset the write counter early would corrupt both results. It further checks the clamp of oversized lengths, the silent drop of zero-length instructions, and the exact dead-time gap, where an off-by-one in the countdown shifts every later write by one cycle.

// File: rtl/vseq_pkg.sv
`timescale 1ns/1ps
package vseq_pkg;
  parameter int DATA_W      = 32;
  parameter int NUM_REGS    = 8;
  parameter int MAX_LEN     = 64;
  parameter int PIPE_DEPTH  = 6;
  parameter int DEAD_CYCLES = 4;   // must be at least 1

  localparam int REG_W  = $clog2(NUM_REGS);
  localparam int IDX_W  = $clog2(MAX_LEN);
  localparam int LEN_W  = IDX_W + 1;
  localparam int DEAD_W = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_XOR = 2'd3
  } vop_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_DEAD = 2'd2
  } seq_state_e;

  // control -> datapath: one element launch
  typedef struct packed {
    logic             fire;
    vop_e             op;
    logic [REG_W-1:0] dst;
    logic [IDX_W-1:0] idx;
    logic             last;
  } elem_cmd_t;

  // one pipeline stage
  typedef struct packed {
    logic              valid;
    logic [REG_W-1:0]  dst;
    logic [IDX_W-1:0]  idx;
    logic              last;
    logic [DATA_W-1:0] data;
  } pipe_slot_t;
endpackage

// File: rtl/vseq_track.sv
`timescale 1ns/1ps
// Per-register pending-write flag and written-element counter.
module vseq_track
  import vseq_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           claimEn,
  input  logic [REG_W-1:0]               claimReg,
  input  logic                           wrEn,
  input  logic [REG_W-1:0]               wrReg,
  input  logic                           wrLast,
  output logic [NUM_REGS-1:0]            liveVec,
  output logic [NUM_REGS-1:0][LEN_W-1:0] wrCnt
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic             live;
    logic [LEN_W-1:0] cnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        live <= 1'b0;
        cnt  <= '0;
      end else if (claimEn && claimReg == REG_W'(g)) begin
        live <= 1'b1;
        cnt  <= '0;
      end else if (wrEn && wrReg == REG_W'(g)) begin
        cnt <= cnt + 1'b1;
        if (wrLast) live <= 1'b0;
      end
    end

    assign liveVec[g] = live;
    assign wrCnt[g]   = cnt;
  end
endmodule

// File: rtl/vseq_ctrl.sv
`timescale 1ns/1ps
// Sequencer control: issue acceptance, dead time, chaining stalls, element stepping.
module vseq_ctrl
  import vseq_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           chainEn,
  input  logic                           issueValid,
  output logic                           issueReady,
  input  logic [1:0]                     issueOp,
  input  logic [REG_W-1:0]               issueDst,
  input  logic [REG_W-1:0]               issueSrcA,
  input  logic [REG_W-1:0]               issueSrcB,
  input  logic [LEN_W-1:0]               issueLen,
  input  logic [NUM_REGS-1:0]            liveVec,
  input  logic [NUM_REGS-1:0][LEN_W-1:0] wrCnt,
  output logic                           claimEn,
  output logic [REG_W-1:0]               claimReg,
  output logic [REG_W-1:0]               rdRegA,
  output logic [REG_W-1:0]               rdRegB,
  output logic [IDX_W-1:0]               rdIdx,
  output logic                           running,
  output elem_cmd_t                      cmd
);
  seq_state_e       state;
  logic [DEAD_W-1:0] deadCnt;
  vop_e             curOp;
  logic [REG_W-1:0] curDst, curSrcA, curSrcB;
  logic [LEN_W-1:0] curLen;
  logic [IDX_W-1:0] curIdx;
  logic             waitA, waitB;

  logic [LEN_W-1:0] effLen;
  logic             deadDone, slotFree, accept;
  logic             okA, okB, fire, lastElem;

  always_comb begin
    effLen     = (issueLen > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : issueLen;
    deadDone   = (deadCnt == DEAD_W'(DEAD_CYCLES - 1));
    slotFree   = (state == S_IDLE) || (state == S_DEAD && deadDone);
    issueReady = slotFree && !liveVec[issueDst];
    accept     = issueValid && issueReady && (issueLen != '0);

    // a source waits only on a producer that was pending when this instruction issued
    okA = !waitA || !liveVec[curSrcA] ||
          (chainEn && (wrCnt[curSrcA] > {1'b0, curIdx}));
    okB = !waitB || !liveVec[curSrcB] ||
          (chainEn && (wrCnt[curSrcB] > {1'b0, curIdx}));

    fire     = (state == S_RUN) && okA && okB;
    lastElem = ({1'b0, curIdx} == (curLen - 1'b1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      deadCnt <= '0;
      curOp   <= OP_ADD;
      curDst  <= '0;
      curSrcA <= '0;
      curSrcB <= '0;
      curLen  <= '0;
      curIdx  <= '0;
      waitA   <= 1'b0;
      waitB   <= 1'b0;
    end else begin
      if (accept) begin
        curOp   <= vop_e'(issueOp);
        curDst  <= issueDst;
        curSrcA <= issueSrcA;
        curSrcB <= issueSrcB;
        curLen  <= effLen;
        curIdx  <= '0;
        waitA   <= liveVec[issueSrcA];
        waitB   <= liveVec[issueSrcB];
      end
      unique case (state)
        S_IDLE: if (accept) state <= S_RUN;
        S_RUN: begin
          if (fire) begin
            if (lastElem) begin
              state   <= S_DEAD;
              deadCnt <= '0;
            end else begin
              curIdx <= curIdx + 1'b1;
            end
          end
        end
        S_DEAD: begin
          if (deadDone) state <= accept ? S_RUN : S_IDLE;
          else          deadCnt <= deadCnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign claimEn  = accept;
  assign claimReg = issueDst;
  assign rdRegA   = curSrcA;
  assign rdRegB   = curSrcB;
  assign rdIdx    = curIdx;
  assign running  = (state == S_RUN);

  always_comb begin
    cmd.fire = fire;
    cmd.op   = curOp;
    cmd.dst  = curDst;
    cmd.idx  = curIdx;
    cmd.last = lastElem;
  end
endmodule

// File: rtl/vseq_datapath.sv
`timescale 1ns/1ps
// Element compute followed by PIPE_DEPTH register stages, write port at the end.
module vseq_datapath
  import vseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  elem_cmd_t         cmd,
  input  logic [DATA_W-1:0] rdDataA,
  input  logic [DATA_W-1:0] rdDataB,
  output logic              wrEn,
  output logic [REG_W-1:0]  wrReg,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [DATA_W-1:0] wrData,
  output logic              wrLast,
  output logic              pipeBusy
);
  logic [DATA_W-1:0]     result;
  logic [PIPE_DEPTH-1:0] validVec;

  always_comb begin
    unique case (cmd.op)
      OP_ADD:  result = rdDataA + rdDataB;
      OP_SUB:  result = rdDataA - rdDataB;
      OP_MUL:  result = rdDataA * rdDataB;
      default: result = rdDataA ^ rdDataB;
    endcase
  end

  for (genvar g = 0; g < PIPE_DEPTH; g++) begin : gStage
    pipe_slot_t slotD, slotQ;
    if (g == 0) begin : gIn
      always_comb begin
        slotD.valid = cmd.fire;
        slotD.dst   = cmd.dst;
        slotD.idx   = cmd.idx;
        slotD.last  = cmd.last;
        slotD.data  = result;
      end
    end else begin : gMid
      assign slotD = gStage[g-1].slotQ;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slotQ <= '0;
      else       slotQ <= slotD;
    end

    assign validVec[g] = slotQ.valid;
  end

  assign wrEn     = gStage[PIPE_DEPTH-1].slotQ.valid;
  assign wrReg    = gStage[PIPE_DEPTH-1].slotQ.dst;
  assign wrIdx    = gStage[PIPE_DEPTH-1].slotQ.idx;
  assign wrData   = gStage[PIPE_DEPTH-1].slotQ.data;
  assign wrLast   = gStage[PIPE_DEPTH-1].slotQ.valid && gStage[PIPE_DEPTH-1].slotQ.last;
  assign pipeBusy = |validVec;
endmodule

// File: rtl/chain_vec_seq.sv
`timescale 1ns/1ps
module chain_vec_seq
  import vseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              chainEn,
  input  logic              issueValid,
  output logic              issueReady,
  input  logic [1:0]        issueOp,
  input  logic [REG_W-1:0]  issueDst,
  input  logic [REG_W-1:0]  issueSrcA,
  input  logic [REG_W-1:0]  issueSrcB,
  input  logic [LEN_W-1:0]  issueLen,
  output logic [REG_W-1:0]  rdRegA,
  output logic [REG_W-1:0]  rdRegB,
  output logic [IDX_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] rdDataA,
  input  logic [DATA_W-1:0] rdDataB,
  output logic              wrEn,
  output logic [REG_W-1:0]  wrReg,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              done
);
  logic                           claimEn;
  logic [REG_W-1:0]               claimReg;
  logic [NUM_REGS-1:0]            liveVec;
  logic [NUM_REGS-1:0][LEN_W-1:0] wrCnt;
  logic                           running, pipeBusy, wrLast;
  elem_cmd_t                      cmd;

  vseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chainEn(chainEn),
    .issueValid(issueValid), .issueReady(issueReady), .issueOp(issueOp),
    .issueDst(issueDst), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .issueLen(issueLen), .liveVec(liveVec), .wrCnt(wrCnt),
    .claimEn(claimEn), .claimReg(claimReg),
    .rdRegA(rdRegA), .rdRegB(rdRegB), .rdIdx(rdIdx),
    .running(running), .cmd(cmd)
  );

  vseq_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrReg(wrReg), .wrIdx(wrIdx), .wrData(wrData),
    .wrLast(wrLast), .pipeBusy(pipeBusy)
  );

  vseq_track u_track (
    .clk(clk), .rstN(rstN), .claimEn(claimEn), .claimReg(claimReg),
    .wrEn(wrEn), .wrReg(wrReg), .wrLast(wrLast),
    .liveVec(liveVec), .wrCnt(wrCnt)
  );

  assign busy = running | pipeBusy;
  assign done = wrLast;
endmodule

// File: rtl/vseq_checks.sv
`timescale 1ns/1ps
module vseq_checks
  import vseq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             issueValid,
  input logic             issueReady,
  input logic [LEN_W-1:0] issueLen,
  input logic             wrEn,
  input logic [REG_W-1:0] wrReg,
  input logic [IDX_W-1:0] wrIdx,
  input logic             busy,
  input logic             done
);
  a_r3_consecutive_writes: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !done) |=> (wrEn && wrIdx == $past(wrIdx) + 1'b1 && wrReg == $past(wrReg)));

  a_r11_done_with_write: assert property (@(posedge clk) disable iff (!rstN)
    done |-> wrEn);

  a_r10_busy_covers_write: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busy);

  a_r10_busy_after_issue: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(issueValid && issueReady && issueLen != '0));

  a_r9_zero_len_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && issueLen == '0 && !busy) |=> !busy);

  a_r7_single_accept: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && issueLen != '0) |=> !issueReady);
endmodule

bind chain_vec_seq vseq_checks u_checks (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(issueReady),
  .issueLen(issueLen), .wrEn(wrEn), .wrReg(wrReg), .wrIdx(wrIdx),
  .busy(busy), .done(done)
);

// File: tb/chain_vec_seq_test.sv
`timescale 1ns/1ps
module chain_vec_seq_test;
  import vseq_pkg::*;

  logic              clk = 1'b0;
  logic              rstN;
  logic              chainEn;
  logic              issueValid;
  logic              issueReady;
  logic [1:0]        issueOp;
  logic [REG_W-1:0]  issueDst, issueSrcA, issueSrcB;
  logic [LEN_W-1:0]  issueLen;
  logic [REG_W-1:0]  rdRegA, rdRegB;
  logic [IDX_W-1:0]  rdIdx;
  logic [DATA_W-1:0] rdDataA, rdDataB;
  logic              wrEn;
  logic [REG_W-1:0]  wrReg;
  logic [IDX_W-1:0]  wrIdx;
  logic [DATA_W-1:0] wrData;
  logic              busy, done;

  always #2.5 clk = ~clk;

  chain_vec_seq uut (
    .clk(clk), .rstN(rstN), .chainEn(chainEn),
    .issueValid(issueValid), .issueReady(issueReady), .issueOp(issueOp),
    .issueDst(issueDst), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .issueLen(issueLen), .rdRegA(rdRegA), .rdRegB(rdRegB), .rdIdx(rdIdx),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .wrEn(wrEn), .wrReg(wrReg),
    .wrIdx(wrIdx), .wrData(wrData), .busy(busy), .done(done)
  );

  // register file model and golden copy
  logic [DATA_W-1:0] rf   [NUM_REGS][MAX_LEN];
  logic [DATA_W-1:0] gold [NUM_REGS][MAX_LEN];

  function automatic logic [DATA_W-1:0] patVal(input int r, input int i);
    return DATA_W'((r + 1) * 1103 + i * (i + 3) + (r << 20));
  endfunction

  function automatic logic [DATA_W-1:0] opRes(input int op, input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] p;
    p = a * b;
    case (op)
      0: return a + b;
      1: return a - b;
      2: return p;
      default: return a ^ b;
    endcase
  endfunction

  assign rdDataA = rf[rdRegA][rdIdx];
  assign rdDataB = rf[rdRegB][rdIdx];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++)
        for (int i = 0; i < MAX_LEN; i++) rf[r][i] <= patVal(r, i);
    end else if (wrEn) begin
      rf[wrReg][wrIdx] <= wrData;
    end
  end

  // cycle counter and write monitor (sampled on the falling edge)
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int firstWr [64];
  int doneCyc [64];
  int nF = 0, nD = 0, nW = 0;
  always @(negedge clk) begin
    if (rstN && wrEn) begin
      nW <= nW + 1;
      if (wrIdx == '0) begin firstWr[nF % 64] <= cyc; nF <= nF + 1; end
      if (done)        begin doneCyc[nD % 64] <= cyc; nD <= nD + 1; end
    end
  end

  int nChecks = 0, nFail = 0;
  int lastAcc;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic issue(input int op, input int dst, input int a, input int b, input int len);
    int eff;
    issueValid = 1'b1;
    issueOp    = 2'(op);
    issueDst   = REG_W'(dst);
    issueSrcA  = REG_W'(a);
    issueSrcB  = REG_W'(b);
    issueLen   = LEN_W'(len);
    #1;
    while (!issueReady) begin @(negedge clk); #1; end
    lastAcc = cyc;
    eff = (len > MAX_LEN) ? MAX_LEN : len;
    for (int i = 0; i < eff; i++) gold[dst][i] = opRes(op, gold[a][i], gold[b][i]);
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
    repeat (DEAD_CYCLES + 1) @(negedge clk);
  endtask

  task automatic checkRegs(input string req);
    int bad = 0;
    for (int r = 0; r < NUM_REGS; r++)
      for (int i = 0; i < MAX_LEN; i++)
        if (rf[r][i] !== gold[r][i]) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  task automatic testReset();
    check(issueReady === 1'b1, "R1 ready", issueReady, 1);
    check(busy === 1'b0, "R1 busy", busy, 0);
    check(done === 1'b0, "R1 done", done, 0);
    check(wrEn === 1'b0, "R1 wrEn", wrEn, 0);
  endtask

  task automatic testOps();
    int bF = nF, bD = nD, bW = nW, acc;
    issue(0, 2, 0, 1, 64); acc = lastAcc; waitIdle();
    check(firstWr[bF % 64] - acc == PIPE_DEPTH + 1, "R3 latency",
          firstWr[bF % 64] - acc, PIPE_DEPTH + 1);
    check(doneCyc[bD % 64] - firstWr[bF % 64] == 63, "R3 one per cycle",
          doneCyc[bD % 64] - firstWr[bF % 64], 63);
    issue(1, 3, 1, 0, 17); waitIdle();
    issue(2, 4, 2, 5, 40); waitIdle();
    issue(3, 6, 7, 3, 9);  waitIdle();
    check(nW - bW == 64 + 17 + 40 + 9, "R2 write count", nW - bW, 130);
    check(nD - bD == 4, "R11 done count", nD - bD, 4);
    checkRegs("R2 results");
  endtask

  task automatic testDead();
    int bF = nF, bD = nD;
    issue(0, 1, 6, 7, 5);
    issue(1, 0, 4, 5, 8);
    waitIdle();
    check(firstWr[(bF + 1) % 64] - doneCyc[bD % 64] == DEAD_CYCLES + 1, "R4 dead gap",
          firstWr[(bF + 1) % 64] - doneCyc[bD % 64], DEAD_CYCLES + 1);
    checkRegs("R4 results");
  endtask

  task automatic testChain(input bit en, input int len, input string req);
    int bF = nF, bD = nD, exp, got;
    chainEn = en;
    issue(0, 3, 0, 1, len);
    issue(2, 5, 3, 2, len);
    waitIdle();
    if (en) exp = (DEAD_CYCLES + 1 > PIPE_DEPTH + 2 - len) ? DEAD_CYCLES + 1 : PIPE_DEPTH + 2 - len;
    else    exp = PIPE_DEPTH + 1;
    got = firstWr[(bF + 1) % 64] - doneCyc[bD % 64];
    check(got == exp, req, got, exp);
    checkRegs(req);
    chainEn = 1'b1;
  endtask

  task automatic testWaw();
    int bF = nF, bD = nD, got;
    issue(0, 5, 0, 1, 4);
    issue(3, 5, 2, 3, 4);
    waitIdle();
    got = firstWr[(bF + 1) % 64] - doneCyc[bD % 64];
    check(got == PIPE_DEPTH + 2, "R7 same-destination gap", got, PIPE_DEPTH + 2);
    checkRegs("R7 last writer wins");
  endtask

  task automatic testClamp();
    int bW = nW;
    issue(1, 7, 0, 2, 100); waitIdle();
    check(nW - bW == MAX_LEN, "R8 clamp count", nW - bW, MAX_LEN);
    checkRegs("R8 results");
  endtask

  task automatic testZero();
    int seen = 0, bW = nW;
    issue(0, 6, 0, 1, 0);
    for (int k = 0; k < 20; k++) begin
      if (busy || wrEn || !issueReady) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R9 zero length quiet", seen, 0);
    check(nW == bW, "R9 no writes", nW - bW, 0);
    checkRegs("R9 registers unchanged");
  endtask

  task automatic testBusy();
    issue(0, 4, 1, 2, 4);
    check(busy === 1'b1, "R10 busy after issue", busy, 1);
    while (!done) @(negedge clk);
    check(busy === 1'b1, "R10 busy at last write", busy, 1);
    @(negedge clk);
    check(busy === 1'b0, "R10 busy drops", busy, 0);
    check(done === 1'b0, "R11 done single pulse", done, 0);
    waitIdle();
    checkRegs("R10 results");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; chainEn = 1'b1; issueValid = 1'b0;
    issueOp = '0; issueDst = '0; issueSrcA = '0; issueSrcB = '0; issueLen = '0;
    for (int r = 0; r < NUM_REGS; r++)
      for (int i = 0; i < MAX_LEN; i++) gold[r][i] = patVal(r, i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOps();
    testDead();
    testChain(1'b1, 3, "R5 chained len 3");
    testChain(1'b1, 2, "R5 chained len 2 stall");
    testChain(1'b0, 3, "R6 unchained");
    testWaw();
    testClamp();
    testZero();
    testBusy();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule